// File: doc/BRIEF.md
# Multi-Event Sample Buffer Manager

This block holds the samples of triggered events in a small internal memory, cut into equal slots. A run-time input selects eight slots or four slots; with four, each slot is twice as deep. A trigger opens a slot. Sample strobes fill it in order. A one-cycle end strobe then carries a good/bad verdict. A good event is kept. A bad event, or one with no samples, gives its slot back at once.

A read request streams the oldest kept event out, one sample per cycle. The slot is freed as the last sample leaves. Slots are used and drained strictly in the order events arrive. A new event may be filled while an older one is being streamed out.

When every slot holds an unread good event, a further trigger is dropped. Its samples never reach the memory, and the stored events stay as they are. An 8-bit counter of dropped events saturates at its top value. A synchronous soft reset discards all stored events and rewinds the slot pointers. It leaves the drop counter alone and does not touch the slot-count selection.

Top module: `mbm_event_buffers`

## Requirements
- R1: After rst_n or a soft_rst pulse, empty is 1, full is 0 and rd_valid is 0. A soft reset discards every stored event but keeps lost_cnt.
- R2: With cfg_eight=1 there are 8 slots of 4 samples each. With cfg_eight=0 there are 4 slots of 8 samples each. full rises when that many good events are stored, and not before.
- R3: A trigger seen while idle and not full opens an event. Each later cycle with wr_valid high and ev_end low stores one sample until the slot holds its capacity. Further samples are dropped.
- R4: On ev_end, an event is kept if ev_good=1 and it holds at least one sample. Otherwise its slot is released and the stored-event count is unchanged.
- R5: A trigger seen while idle and full loses that event. Its samples are ignored, stored events are unaffected, and lost_cnt rises by one, saturating at 255.
- R6: A read request seen while no readout runs and at least one event is stored starts a readout. rd_valid is high two cycles after the request is registered. The oldest event's samples follow in written order, one per cycle, with rd_last on the final one, and the slot is then freed.
- R7: A read request while empty produces no rd_valid and changes nothing. A read request during a readout is ignored.
- R8: An event can be triggered, filled and kept while a readout of an older event is streaming.
- R9: A trigger that arrives while an event is being filled is ignored. A sample strobe in that same cycle is still stored.
- R10: empty is 1 exactly when no good event is stored. full and empty are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of stored events and pointers |
| cfg_eight | input | 1 | 1: eight slots, 0: four slots; change only while empty and idle |
| trig | input | 1 | Starts an event |
| wr_valid | input | 1 | Sample strobe |
| wr_data | input | DATA_W | Sample value |
| ev_end | input | 1 | One-cycle end-of-event strobe |
| ev_good | input | 1 | Verdict sampled with ev_end |
| rd_req | input | 1 | Request readout of the oldest stored event |
| rd_valid | output | 1 | rd_data holds a sample |
| rd_data | output | DATA_W | Sample being read out |
| rd_last | output | 1 | Final sample of the event |
| full | output | 1 | Every slot holds a stored event |
| empty | output | 1 | No stored event |
| lost_cnt | output | 8 | Saturating count of dropped events |

## Verification
The hardest state to reach is the slot ring wrapping past its end while stored events sit on both sides of the wrap. The drop counter must also reach saturation with stored data still intact afterwards. The bench fills all eight slots, drains two, and refills across the wrap. It then fills the ring again and fires more than 255 dropped triggers, and finally drains every slot against a model of the stored samples. Overlap of filling and streaming is produced by driving an event and a readout from parallel branches.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    typedef enum logic [1:0] {
        ACQ_IDLE = 2'd0,
        ACQ_FILL = 2'd1,
        ACQ_DROP = 2'd2
    } acq_state_e;

    localparam int unsigned LOST_W = 8;
endpackage

// File: rtl/mbm_store.sv
module mbm_store #(
    parameter int unsigned DATA_W = 10,
    parameter int unsigned WORDS  = 32,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mbm_acq.sv
module mbm_acq
    import mbm_pkg::*;
#(
    parameter int unsigned MAX_BUFS = 8,
    parameter int unsigned WORDS    = 32,
    localparam int unsigned ADDR_W  = $clog2(WORDS),
    localparam int unsigned PTR_W   = $clog2(MAX_BUFS),
    localparam int unsigned SLOT_HI = WORDS / MAX_BUFS,
    localparam int unsigned SLOT_LO = WORDS / (MAX_BUFS / 2),
    localparam int unsigned LEN_W   = $clog2(SLOT_LO + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_eight,
    input  logic              trig,
    input  logic              wr_valid,
    input  logic              ev_end,
    input  logic              ev_good,
    input  logic              full,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              commit,
    output logic [PTR_W-1:0]  commit_ptr,
    output logic [LEN_W-1:0]  commit_len,
    output logic [LOST_W-1:0] lost_cnt,
    output logic              idle
);
    typedef struct packed {
        acq_state_e        st;
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  cnt;
        logic [LOST_W-1:0] lost;
    } acq_regs_t;

    acq_regs_t q, d;
    logic [LEN_W-1:0]  cap;
    logic [PTR_W-1:0]  last_ptr;
    logic [ADDR_W-1:0] base;

    always_comb begin
        cap      = cfg_eight ? LEN_W'(SLOT_HI) : LEN_W'(SLOT_LO);
        last_ptr = cfg_eight ? PTR_W'(MAX_BUFS - 1) : PTR_W'(MAX_BUFS / 2 - 1);
        base     = cfg_eight ? ADDR_W'(q.ptr) * ADDR_W'(SLOT_HI)
                             : ADDR_W'(q.ptr) * ADDR_W'(SLOT_LO);
        mem_waddr = base + ADDR_W'(q.cnt);
        mem_we    = 1'b0;
        commit    = 1'b0;
        d         = q;
        if (soft_rst) begin
            d.st  = ACQ_IDLE;
            d.ptr = '0;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ACQ_IDLE: begin
                    if (trig) begin
                        d.cnt = '0;
                        if (full) begin
                            d.st = ACQ_DROP;
                            if (q.lost != '1) begin
                                d.lost = q.lost + LOST_W'(1);
                            end
                        end else begin
                            d.st = ACQ_FILL;
                        end
                    end
                end
                ACQ_FILL: begin
                    if (ev_end) begin
                        d.st = ACQ_IDLE;
                        if (ev_good && (q.cnt != '0)) begin
                            commit = 1'b1;
                            d.ptr  = (q.ptr == last_ptr) ? '0 : q.ptr + PTR_W'(1);
                        end
                    end else if (wr_valid && (q.cnt < cap)) begin
                        mem_we = 1'b1;
                        d.cnt  = q.cnt + LEN_W'(1);
                    end
                end
                ACQ_DROP: begin
                    if (ev_end) begin
                        d.st = ACQ_IDLE;
                    end
                end
                default: d.st = ACQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ACQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign commit_ptr = q.ptr;
    assign commit_len = q.cnt;
    assign lost_cnt   = q.lost;
    assign idle       = (q.st == ACQ_IDLE);
endmodule

// File: rtl/mbm_drain.sv
module mbm_drain #(
    parameter int unsigned DATA_W   = 10,
    parameter int unsigned MAX_BUFS = 8,
    parameter int unsigned WORDS    = 32,
    localparam int unsigned ADDR_W  = $clog2(WORDS),
    localparam int unsigned PTR_W   = $clog2(MAX_BUFS),
    localparam int unsigned SLOT_HI = WORDS / MAX_BUFS,
    localparam int unsigned SLOT_LO = WORDS / (MAX_BUFS / 2),
    localparam int unsigned LEN_W   = $clog2(SLOT_LO + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_eight,
    input  logic              rd_req,
    input  logic              empty,
    input  logic [LEN_W-1:0]  head_len,
    output logic [PTR_W-1:0]  head_ptr,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rls,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last
);
    typedef struct packed {
        logic              busy;
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  idx;
        logic              vld;
        logic              last;
        logic [DATA_W-1:0] data;
    } drain_regs_t;

    drain_regs_t q, d;
    logic [PTR_W-1:0]  last_ptr;
    logic [ADDR_W-1:0] base;

    always_comb begin
        last_ptr  = cfg_eight ? PTR_W'(MAX_BUFS - 1) : PTR_W'(MAX_BUFS / 2 - 1);
        base      = cfg_eight ? ADDR_W'(q.ptr) * ADDR_W'(SLOT_HI)
                              : ADDR_W'(q.ptr) * ADDR_W'(SLOT_LO);
        mem_raddr = base + ADDR_W'(q.idx);
        rls       = 1'b0;
        d         = q;
        d.vld     = 1'b0;
        d.last    = 1'b0;
        if (soft_rst) begin
            d.busy = 1'b0;
            d.ptr  = '0;
            d.idx  = '0;
        end else if (!q.busy) begin
            if (rd_req && !empty) begin
                d.busy = 1'b1;
                d.idx  = '0;
            end
        end else begin
            d.vld  = 1'b1;
            d.data = mem_rdata;
            d.idx  = q.idx + LEN_W'(1);
            if ((q.idx + LEN_W'(1)) == head_len) begin
                d.last = 1'b1;
                d.busy = 1'b0;
                rls    = 1'b1;
                d.ptr  = (q.ptr == last_ptr) ? '0 : q.ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_ptr = q.ptr;
    assign rd_valid = q.vld;
    assign rd_data  = q.data;
    assign rd_last  = q.last;
endmodule

// File: rtl/mbm_event_buffers.sv
module mbm_event_buffers
    import mbm_pkg::*;
#(
    parameter int unsigned DATA_W   = 10,
    parameter int unsigned MAX_BUFS = 8,
    parameter int unsigned WORDS    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_eight,
    input  logic              trig,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_end,
    input  logic              ev_good,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              full,
    output logic              empty,
    output logic [7:0]        lost_cnt
);
    localparam int unsigned ADDR_W  = $clog2(WORDS);
    localparam int unsigned PTR_W   = $clog2(MAX_BUFS);
    localparam int unsigned SLOT_LO = WORDS / (MAX_BUFS / 2);
    localparam int unsigned LEN_W   = $clog2(SLOT_LO + 1);
    localparam int unsigned OCC_W   = $clog2(MAX_BUFS + 1);

    typedef struct packed {
        logic [OCC_W-1:0]                occ;
        logic [MAX_BUFS-1:0][LEN_W-1:0] len;
    } top_regs_t;

    top_regs_t q, d;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              commit;
    logic [PTR_W-1:0]  commit_ptr;
    logic [LEN_W-1:0]  commit_len;
    logic              acq_idle;
    logic              rls;
    logic [PTR_W-1:0]  head_ptr;
    logic [LEN_W-1:0]  head_len;

    mbm_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    mbm_acq #(.MAX_BUFS(MAX_BUFS), .WORDS(WORDS)) u_acq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .cfg_eight  (cfg_eight),
        .trig       (trig),
        .wr_valid   (wr_valid),
        .ev_end     (ev_end),
        .ev_good    (ev_good),
        .full       (full),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .commit     (commit),
        .commit_ptr (commit_ptr),
        .commit_len (commit_len),
        .lost_cnt   (lost_cnt),
        .idle       (acq_idle)
    );

    mbm_drain #(.DATA_W(DATA_W), .MAX_BUFS(MAX_BUFS), .WORDS(WORDS)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .cfg_eight (cfg_eight),
        .rd_req    (rd_req),
        .empty     (empty),
        .head_len  (head_len),
        .head_ptr  (head_ptr),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .rls       (rls),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_last   (rd_last)
    );

    always_comb begin
        d = q;
        if (soft_rst) begin
            d.occ = '0;
        end else begin
            d.occ = q.occ + OCC_W'(commit) - OCC_W'(rls);
            if (commit) begin
                d.len[commit_ptr] = commit_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_len = q.len[head_ptr];
    assign full     = (q.occ == (cfg_eight ? OCC_W'(MAX_BUFS) : OCC_W'(MAX_BUFS / 2)));
    assign empty    = (q.occ == '0);
endmodule

// File: rtl/mbm_event_buffers_chk.sv
module mbm_event_buffers_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       trig,
    input logic       rd_req,
    input logic       rd_valid,
    input logic       rd_last,
    input logic       full,
    input logic       empty,
    input logic       acq_idle,
    input logic [7:0] lost_cnt
);
    // R10: flags never both set
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R7: a request against an empty store yields no data
    a_r7_no_data_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> !rd_valid);

    // R6: last marker only on a valid word, and the burst stops after it
    a_r6_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
    a_r6_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> !rd_valid);

    // R5: drop while full counts one lost event
    a_r5_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && full && acq_idle && !soft_rst && (lost_cnt != 8'hFF))
        |=> (lost_cnt == $past(lost_cnt) + 8'd1));

    // R5: counter only steps up by one, and holds at saturation
    a_r5_lost_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_cnt != $past(lost_cnt)) |-> (lost_cnt == $past(lost_cnt) + 8'd1));
    a_r5_lost_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lost_cnt) == 8'hFF) |-> (lost_cnt == 8'hFF));

    // R1: soft reset empties the store and stops readout
    a_r1_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (empty && !rd_valid));
endmodule

bind mbm_event_buffers mbm_event_buffers_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .trig     (trig),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_last  (rd_last),
    .full     (full),
    .empty    (empty),
    .acq_idle (acq_idle),
    .lost_cnt (lost_cnt)
);

// File: tb/mbm_event_buffers_bench.sv
module mbm_event_buffers_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 10;
    localparam int NVEC = 7;
    // vector: {samples[3:0], good, seed[7:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd3, 1'b1, 8'h10},
        {4'd2, 1'b0, 8'h20},
        {4'd9, 1'b1, 8'h30},
        {4'd0, 1'b1, 8'h40},
        {4'd5, 1'b1, 8'h50},
        {4'd1, 1'b1, 8'h60},
        {4'd4, 1'b1, 8'h70}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, cfg_eight = 1'b0, trig = 1'b0, wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic ev_end = 1'b0, ev_good = 1'b0, rd_req = 1'b0;
    logic rd_valid, rd_last, full, empty;
    logic [DATA_W-1:0] rd_data;
    logic [7:0] lost_cnt;

    int n_tests = 0, n_fail = 0;
    int mdat [16][8];
    int mlen [16];
    int mhead = 0, mtail = 0, mcnt = 0, nbuf_m = 4, cap_m = 8, lost_m = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbm_event_buffers u_mbm_event_buffers (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_eight(cfg_eight),
        .trig(trig), .wr_valid(wr_valid), .wr_data(wr_data), .ev_end(ev_end),
        .ev_good(ev_good), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_last(rd_last), .full(full), .empty(empty), .lost_cnt(lost_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check(req, "full", int'(full), int'(mcnt == nbuf_m));
        check(req, "empty", int'(empty), int'(mcnt == 0));
        check(req, "lost_cnt", int'(lost_cnt), lost_m);
    endtask

    task automatic do_event(input int n, input bit good, input int seed, input int extra_trig);
        bit drop;
        drop = (mcnt == nbuf_m);
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = DATA_W'(seed + i);
            trig     = (i == extra_trig);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        trig     = 1'b0;
        ev_end   = 1'b1;
        ev_good  = good;
        @(negedge clk);
        ev_end  = 1'b0;
        ev_good = 1'b0;
        if (drop) begin
            if (lost_m < 255) lost_m++;
        end else if (good && n > 0) begin
            mlen[mtail] = (n < cap_m) ? n : cap_m;
            for (int i = 0; i < mlen[mtail]; i++) mdat[mtail][i] = (seed + i) % 1024;
            mtail = (mtail + 1) % 16;
            mcnt++;
        end
    endtask

    task automatic read_one(input string req, input bit poke);
        int got;
        bit had;
        bit saw_last;
        got = 0;
        saw_last = 1'b0;
        had = (mcnt > 0);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        for (int t = 0; t < 30; t++) begin
            @(negedge clk);
            rd_req = 1'b0;
            if (rd_valid) begin
                if (had && got < mlen[mhead])
                    check(req, "rd_data", int'(rd_data), mdat[mhead][got]);
                got++;
                if (poke && got == 1) rd_req = 1'b1;
                if (rd_last) begin
                    saw_last = 1'b1;
                    break;
                end
            end
        end
        rd_req = 1'b0;
        if (had) begin
            check(req, "word count", got, mlen[mhead]);
            check(req, "rd_last seen", int'(saw_last), 1);
            mhead = (mhead + 1) % 16;
            mcnt--;
        end else begin
            check(req, "words on empty read", got, 0);
        end
    endtask

    task automatic pulse_soft();
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) soft_rst = 1'b0;
        mhead = 0; mtail = 0; mcnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "empty after reset", int'(empty), 1);
        check("R1", "full after reset", int'(full), 0);
        check("R1", "rd_valid after reset", int'(rd_valid), 0);
        check("R1", "lost after reset", int'(lost_cnt), 0);

        // R2 R3 R4 R5 R10: table of events in four-slot mode
        for (int v = 0; v < NVEC; v++) begin
            do_event(int'(VEC[v][12:9]), VEC[v][8], int'(VEC[v][7:0]), -1);
            check_flags("R10");
        end
        // R6 oldest first, truncated event holds 8 (R3), data intact after drop (R5)
        for (int k = 0; k < 4; k++) begin
            read_one("R6", 1'b0);
            check_flags("R6");
        end
        // R7 read on empty
        read_one("R7", 1'b0);
        check_flags("R7");

        // R9 trigger inside an event is ignored, its sample kept
        do_event(4, 1'b1, 'h80, 1);
        check_flags("R9");
        read_one("R9", 1'b0);

        // R8 fill while streaming
        do_event(2, 1'b1, 'h90, -1);
        fork
            read_one("R8", 1'b0);
            do_event(3, 1'b1, 'hA0, -1);
        join
        check_flags("R8");
        read_one("R8", 1'b0);

        // R7 request during readout ignored
        do_event(3, 1'b1, 'hB0, -1);
        do_event(2, 1'b1, 'hC0, -1);
        read_one("R7", 1'b1);
        quiet = 0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if (rd_valid) quiet++;
        end
        check("R7", "words after ignored request", quiet, 0);
        read_one("R7", 1'b0);

        // R1 soft reset discards data, keeps lost count
        do_event(2, 1'b1, 'hD0, -1);
        pulse_soft();
        check_flags("R1");
        read_one("R1", 1'b0);

        // R2 eight-slot mode, ring wrap
        cfg_eight = 1'b1;
        nbuf_m = 8;
        cap_m = 4;
        for (int k = 0; k < 7; k++) do_event(6, 1'b1, 16 * k, -1);
        check("R2", "full after 7 of 8", int'(full), 0);
        do_event(6, 1'b1, 'h70, -1);
        check("R2", "full after 8 of 8", int'(full), 1);
        do_event(2, 1'b1, 'h1F0, -1);
        check_flags("R5");
        read_one("R2", 1'b0);
        read_one("R2", 1'b0);
        do_event(3, 1'b1, 'h100, -1);
        do_event(4, 1'b1, 'h120, -1);
        check_flags("R2");
        for (int k = 0; k < 8; k++) read_one("R2", 1'b0);
        check_flags("R2");

        // R5 saturation with full store kept intact
        for (int k = 0; k < 8; k++) do_event(4, 1'b1, 'h200 + 8 * k, -1);
        for (int k = 0; k < 260; k++) do_event(1, 1'b1, 'h3F0, -1);
        check("R5", "lost saturated", int'(lost_cnt), 255);
        check_flags("R5");
        for (int k = 0; k < 8; k++) read_one("R5", 1'b0);
        check_flags("R10");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule